// File: doc/BRIEF.md
# Reference Clock Selector with Glitch-Free Output Gating

This block takes three candidate reference clocks (two clock inputs and an oscillator input), picks one with a two-bit source select, and fans it out to ten identical clock outputs. The outputs are split into two banks of five. They behave the same way, but the banks can be wired to loads at different supply levels elsewhere on the chip. Each output reports a data value and a drive flag, and a clear drive flag means the pin is released to high impedance.

An asynchronous output-enable request controls whether the outputs carry the clock. The request is retimed on the falling edges of whichever reference is currently selected, so the gate opens and closes only while the clock is low. No output pulse is ever shorter than a full high phase of the reference.

Turning the outputs on is a two-step sequence. First the outputs are driven low, then they follow the clock. Turning them off is a three-step sequence. The outputs keep following the clock, then they are driven low, and only after the next rising edge are they released. When the oscillator input is not selected, a power-down flag lets the oscillator path be switched off.

Top module: `clk_fanout_gate`

## Requirements
- R1: With `srcSel`=2'b00 the outputs carry `clkIn0`. With 2'b01 they carry `clkIn1`. With 2'b10 or 2'b11 they carry `oscIn` (bit 0 is ignored when bit 1 is set).
- R2: `oscPowerDown` is 1 whenever `srcSel[1]` is 0 and 0 whenever `srcSel[1]` is 1, including during reset.
- R3: After `oeAsync` rises, the data outputs follow the selected clock from the second falling edge of that clock onward. The first high level on the outputs appears at the rising edge after that falling edge.
- R4: From the rise of `oeAsync` until the second falling edge, every output has drive=1 and data=0. The gated clock never shows a high level in this window, even while the reference is high.
- R5: After `oeAsync` falls, the data outputs keep following the clock up to the second falling edge. From that edge they are held at data=0 with drive=1.
- R6: At the first rising edge of the reference after the forced-low point of R5, the drive flags drop to 0 (high impedance). They stay 1 until that edge.
- R7: All ten outputs in both banks carry identical data and identical drive values at all times.
- R8: If `oeAsync` is raised while the selected clock is not toggling, the outputs are driven with a constant level (data=0, drive=1) and do not change while the clock stays still.
- R9: An active-low `rstN` clears the retiming stages at once. With `oeAsync` low the outputs are then data=0, drive=0. With `oeAsync` high they are data=0, drive=1. After release, two falling edges are again needed before the outputs follow.
- R10: A change of `srcSel` while the outputs are enabled takes effect at once. The outputs follow the newly selected clock from its next edges, and the enable state is not lost.
- R11: A data output can only change from 0 to 1 at a rising edge of the selected reference. The gate never opens or closes while the reference is high.

Port descriptions give the default widths (`NUM_OUTS` = 10, two banks of five).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of the retiming logic |
| clkIn0 | input | 1 | First candidate reference clock |
| clkIn1 | input | 1 | Second candidate reference clock |
| oscIn | input | 1 | Oscillator-path reference clock |
| srcSel | input | 2 | Reference source select (00 in0, 01 in1, 1x oscillator) |
| oeAsync | input | 1 | Asynchronous output-enable request |
| clkOut | output | 10 | Data value of each output, bit 4:0 bank A, bit 9:5 bank B |
| clkOutDrive | output | 10 | Per-output drive flag; 0 means high impedance |
| oscPowerDown | output | 1 | High when the oscillator path is unused |

## Verification
The bench looks at the rising edge between the first and second falling edges after an enable. A design that gated on the first falling edge, or that used a single retiming stage, would put a high pulse there. On disable, it samples just before and just after the rising edge that follows the forced-low point. A design that released the drive too early would float a line that should be low, and one that released it too late would hold it low for an extra cycle.

The source-select sweep covers all four codes, including the code where bit 0 must be ignored, while the outputs stay enabled. Losing the enable state on a switch would show up as missing clock pulses.

The bench also stops the clock and then raises the enable, to catch a design whose idle outputs oscillate or float. It pulses reset while the outputs run, to catch retiming stages that survive reset.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

  // Strobes handed from the enable controller to the output datapath.
  typedef struct packed {
    logic gateOpen;   // outputs follow the reference
    logic driveOn;    // outputs actively driven (else high impedance)
  } gateStrobes_t;

  // Source select codes; bit 1 set always picks the oscillator.
  typedef enum logic [1:0] {
    SRC_IN0     = 2'b00,
    SRC_IN1     = 2'b01,
    SRC_OSC     = 2'b10,
    SRC_OSC_ALT = 2'b11
  } srcSel_e;

endpackage

// File: rtl/clk_fanout_datapath.sv
module clk_fanout_datapath
  import clk_fanout_pkg::*;
#(
  parameter int NUM_OUTS  = 10,
  parameter int BANK_SIZE = 5
) (
  input  logic                clkIn0,
  input  logic                clkIn1,
  input  logic                oscIn,
  input  logic [1:0]          srcSel,
  input  gateStrobes_t        strobes,
  output logic                refClk,
  output logic                oscPowerDown,
  output logic [NUM_OUTS-1:0] clkOut,
  output logic [NUM_OUTS-1:0] clkOutDrive
);

  localparam int NUM_BANKS = (NUM_OUTS + BANK_SIZE - 1) / BANK_SIZE;

  srcSel_e selCode;
  assign selCode = srcSel_e'(srcSel);

  // Reference selection: any code with bit 1 set picks the oscillator.
  always_comb begin
    unique case (selCode)
      SRC_IN0:               refClk = clkIn0;
      SRC_IN1:               refClk = clkIn1;
      SRC_OSC, SRC_OSC_ALT:  refClk = oscIn;
      default:               refClk = clkIn0;
    endcase
  end

  assign oscPowerDown = (selCode == SRC_IN0) || (selCode == SRC_IN1);

  // Gated clock shared by every output of every bank.
  logic gatedClk;
  assign gatedClk = refClk & strobes.gateOpen;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_SIZE;
    localparam int HI = ((b + 1) * BANK_SIZE > NUM_OUTS) ? NUM_OUTS : (b + 1) * BANK_SIZE;
    for (genvar i = LO; i < HI; i++) begin : g_pin
      assign clkOut[i]      = gatedClk;
      assign clkOutDrive[i] = strobes.driveOn;
    end
  end

endmodule

// File: rtl/clk_fanout_enable_ctrl.sv
module clk_fanout_enable_ctrl
  import clk_fanout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         refClk,
  input  logic         rstN,
  input  logic         oeAsync,
  output gateStrobes_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          drainHold;
  logic          armPending;

  // Enable request retimed on falling edges: gate changes only with clock low.
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[LAST-1:0], oeAsync};
  end

  // Keeps the outputs driven low until the rising edge after the gate closes.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) drainHold <= 1'b0;
    else       drainHold <= syncChain[LAST];
  end

  assign armPending = |syncChain[LAST-1:0];

  assign strobes.gateOpen = syncChain[LAST];
  assign strobes.driveOn  = syncChain[LAST] | armPending | drainHold | oeAsync;

endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import clk_fanout_pkg::*;
#(
  parameter int NUM_OUTS    = 10,
  parameter int BANK_SIZE   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                rstN,
  input  logic                clkIn0,
  input  logic                clkIn1,
  input  logic                oscIn,
  input  logic [1:0]          srcSel,
  input  logic                oeAsync,
  output logic [NUM_OUTS-1:0] clkOut,
  output logic [NUM_OUTS-1:0] clkOutDrive,
  output logic                oscPowerDown
);

  logic         refClk;
  gateStrobes_t strobes;

  clk_fanout_enable_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .refClk  (refClk),
    .rstN    (rstN),
    .oeAsync (oeAsync),
    .strobes (strobes)
  );

  clk_fanout_datapath #(
    .NUM_OUTS (NUM_OUTS),
    .BANK_SIZE(BANK_SIZE)
  ) i_dp (
    .clkIn0      (clkIn0),
    .clkIn1      (clkIn1),
    .oscIn       (oscIn),
    .srcSel      (srcSel),
    .strobes     (strobes),
    .refClk      (refClk),
    .oscPowerDown(oscPowerDown),
    .clkOut      (clkOut),
    .clkOutDrive (clkOutDrive)
  );

endmodule

// File: rtl/clk_fanout_gate_chk.sv
module clk_fanout_gate_chk #(
  parameter int NUM_OUTS = 10
) (
  input logic                refClk,
  input logic                rstN,
  input logic [NUM_OUTS-1:0] clkOut,
  input logic [NUM_OUTS-1:0] clkOutDrive,
  input logic                gateOpen,
  input logic                driveOn
);

  // Just before each rising edge the reference is low, so no output may be high.
  assert_low_before_rise_R11: assert property (
    @(posedge refClk) disable iff (!rstN) clkOut == '0);

  // Both banks carry one value for data and one for drive.
  assert_banks_match_R7: assert property (
    @(negedge refClk) disable iff (!rstN)
      (clkOut == '0 || clkOut == '1) && (clkOutDrive == '0 || clkOutDrive == '1));

  // A high data level only ever appears on a driven output.
  assert_data_needs_drive_R4: assert property (
    @(negedge refClk) disable iff (!rstN) (clkOut & ~clkOutDrive) == '0);

  // The gate opens only after a falling edge at which the outputs were already driven.
  assert_armed_before_open_R4: assert property (
    @(negedge refClk) disable iff (!rstN) $rose(gateOpen) |-> $past(driveOn));

  // Release to high impedance happens only once the gate is shut.
  assert_hiz_after_close_R6: assert property (
    @(posedge refClk) disable iff (!rstN) $fell(clkOutDrive[0]) |-> $past(!gateOpen));

endmodule

bind clk_fanout_gate clk_fanout_gate_chk #(.NUM_OUTS(NUM_OUTS)) i_chk (
  .refClk     (refClk),
  .rstN       (rstN),
  .clkOut     (clkOut),
  .clkOutDrive(clkOutDrive),
  .gateOpen   (strobes.gateOpen),
  .driveOn    (strobes.driveOn)
);

// File: tb/test_clk_fanout_gate.sv
`timescale 1ns/1ps
module test_clk_fanout_gate;

  localparam int N = 10;
  localparam logic [N-1:0] ONES = '1;
  localparam logic [N-1:0] ZERO = '0;

  logic         rstN = 1'b0;
  logic         clkIn0 = 1'b0, clkIn1 = 1'b0, oscIn = 1'b0;
  logic         run0 = 1'b1;
  logic [1:0]   srcSel = 2'b00;
  logic         oeAsync = 1'b0;
  logic [N-1:0] clkOut, clkOutDrive;
  logic         oscPowerDown;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  clk_fanout_gate i_clk_fanout_gate (
    .rstN(rstN), .clkIn0(clkIn0), .clkIn1(clkIn1), .oscIn(oscIn),
    .srcSel(srcSel), .oeAsync(oeAsync),
    .clkOut(clkOut), .clkOutDrive(clkOutDrive), .oscPowerDown(oscPowerDown)
  );

  // 100 MHz main reference, plus two unrelated periods.
  initial forever begin #5 if (run0) clkIn0 = ~clkIn0; end
  initial forever #7  clkIn1 = ~clkIn1;
  initial forever #11 oscIn  = ~oscIn;

  task automatic chk(input string tag, input logic [N-1:0] expD, input logic [N-1:0] expE);
    compared++;
    if (clkOut !== expD || clkOutDrive !== expE) begin
      mismatched++;
      $display("FAIL %s: data=%b drive=%b expected data=%b drive=%b @%0t",
               tag, clkOut, clkOutDrive, expD, expE, $time);
    end
  endtask

  task automatic chkPd(input string tag, input logic exp);
    compared++;
    if (oscPowerDown !== exp) begin
      mismatched++;
      $display("FAIL %s: oscPowerDown=%b expected %b", tag, oscPowerDown, exp);
    end
  endtask

  task automatic waitPos();
    case (srcSel)
      2'b00:   @(posedge clkIn0);
      2'b01:   @(posedge clkIn1);
      default: @(posedge oscIn);
    endcase
  endtask

  task automatic waitNeg();
    case (srcSel)
      2'b00:   @(negedge clkIn0);
      2'b01:   @(negedge clkIn1);
      default: @(negedge oscIn);
    endcase
  endtask

  task automatic follow(input string tag, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      waitPos(); #1 chk(tag, ONES, ONES);
      waitNeg(); #1 chk(tag, ZERO, ONES);
    end
  endtask

  task automatic enableSeq();
    waitPos(); #1 oeAsync = 1'b1;
    #1 chk("R4 armed while ref high", ZERO, ONES);
    waitNeg(); #1 chk("R4 first falling edge", ZERO, ONES);
    waitPos(); #1 chk("R4 no pulse before second fall", ZERO, ONES);
    waitNeg(); #1 chk("R3 second falling edge", ZERO, ONES);
    waitPos(); #1 chk("R3 first output pulse", ONES, ONES);
    follow("R1 R7 following", 3);
  endtask

  task automatic disableSeq();
    waitPos(); #1 oeAsync = 1'b0;
    #1 chk("R5 still following", ONES, ONES);
    waitNeg(); #1 chk("R5 first fall", ZERO, ONES);
    waitPos(); #1 chk("R5 pulse before second fall", ONES, ONES);
    waitNeg(); #1 chk("R5 forced low, R6 still driven", ZERO, ONES);
    waitPos(); #1 chk("R6 released at rise", ZERO, ZERO);
    waitNeg(); #1 chk("R6 stays released", ZERO, ZERO);
  endtask

  initial begin
    #23;
    chk("R9 reset state", ZERO, ZERO);
    chkPd("R2 sel 00 in reset", 1'b1);
    @(posedge clkIn0); #1 rstN = 1'b1;
    #1 chk("R9 after release", ZERO, ZERO);

    enableSeq();

    // R10 / R1 / R2: sweep every select code while enabled.
    for (int s = 1; s < 4; s++) begin
      srcSel = 2'(s);
      #1 chkPd("R2 select sweep", (s < 2) ? 1'b1 : 1'b0);
      follow("R10 R1 after source switch", 4);
    end
    srcSel = 2'b00;
    #1 chkPd("R2 back to in0", 1'b1);
    follow("R10 R1 back to in0", 2);

    disableSeq();

    // Enable and disable on the oscillator with the ignored select bit set.
    srcSel = 2'b11;
    enableSeq();
    disableSeq();
    srcSel = 2'b00;

    // R8: no clock toggling.
    @(negedge clkIn0); run0 = 1'b0;
    #2 oeAsync = 1'b1;
    #1 chk("R8 driven low without clock", ZERO, ONES);
    for (int k = 0; k < 8; k++) begin
      #7 chk("R8 static without clock", ZERO, ONES);
    end
    run0 = 1'b1;
    @(posedge clkIn0); #1 chk("R3 restart, not yet open", ZERO, ONES);
    @(negedge clkIn0); @(negedge clkIn0);
    @(posedge clkIn0); #1 chk("R3 restart following", ONES, ONES);

    // R9: reset while running with the enable held high.
    @(posedge clkIn0); #1 rstN = 1'b0;
    #1 chk("R9 reset clears gate", ZERO, ONES);
    @(negedge clkIn0); #1 chk("R9 held in reset", ZERO, ONES);
    @(posedge clkIn0); #1 rstN = 1'b1;
    @(negedge clkIn0); #1 chk("R9 first fall after release", ZERO, ONES);
    @(posedge clkIn0); #1 chk("R9 no pulse yet", ZERO, ONES);
    @(negedge clkIn0);
    @(posedge clkIn0); #1 chk("R9 R3 follows again", ONES, ONES);

    oeAsync = 1'b0;
    repeat (4) @(posedge clkIn0);
    #1 chk("R6 released at end", ZERO, ZERO);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule